// File: doc/BRIEF.md
# Event Counter Group with Set/Clear Control Registers

This block holds a small group of event counters behind a memory-mapped register port. Each counter picks one event line from an incoming vector of single-cycle event pulses. A counter counts a pulse only when all of the following hold: counting is enabled for the whole group, the counter's own enable bit is set, and the filter-match input for that counter is high. The filter match is worked out by a neighbouring block, so this block only stores the filter value and span flag for each counter and drives them out to that block.

Per-counter enable, interrupt enable and overflow status are one-bit-per-counter masks. Each mask has a separate set address and a separate clear address, so software never needs a read-modify-write. A counter that wraps from all ones to zero sets its overflow bit. A level interrupt is raised while an enabled overflow is pending and the interrupt switch is on. Software can preload a counter, for example to half its range, to control when the next overflow occurs. A read-only configuration word and a 128-bit supported-event map describe the block to software.

Top module: `perf_ctr_group`

## Requirements
- R1: After reset, all counters, the enable, interrupt-enable and overflow masks, the global count enable and the interrupt switch read 0, and `irq_o` is low.
- R2: The word at 0xE00 reads the counter count minus one in bits 5:0, the counter width minus one in bits 13:8, 0 in bit 20, and the `GLOBAL_FLT` parameter in bit 23. The words at 0xE20 and 0xE28 return the low and high halves of `EVT_SUPPORT`.
- R3: Each mask has a set address and a clear address: enable at 0xC00 and 0xC20, interrupt enable at 0xC40 and 0xC60, overflow at 0xCC0 and 0xC80. Writing a 1 in bit i sets or clears bit i of the mask. A 0 bit leaves the mask bit unchanged. Both addresses read back the current mask in bits NUM_CTR-1:0.
- R4: Counter i increments by one on a clock edge only when all of these hold: bit 0 of 0xE04 is set, enable bit i is set, `flt_match_i[i]` is high, and the selected event id is below NUM_EVT with `evt_i[id]` high. An event id of NUM_EVT or more never counts.
- R5: Counter i sits at byte address i*4 when CTR_W is 32 or less, and at i*8 otherwise. A write loads the counter from wr_data[CTR_W-1:0], and a read returns its value. Counter slots at or beyond NUM_CTR read 0.
- R6: A counting step from all ones brings the counter to zero and sets overflow bit i.
- R7: `irq_o` is high exactly while bit 0 of 0xE50 is set and some bit is set in both the overflow mask and the interrupt-enable mask.
- R8: The event-type word at 0x400+4i holds the event id in bits 15:0 and the filter span flag in bit 29. The filter word at 0xA00+4i holds 32 bits. Both read back as written, and they drive `flt_span_o[i]` and `flt_val_o[32i+31:32i]`.
- R9: A register write to a counter in the same cycle as a counting step loads the written value, and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 64 | Write data |
| reg_rd | input | 1 | Read strobe; data appears on reg_rdata the cycle after |
| reg_rdata | output | 64 | Read data, held until the next read |
| evt_i | input | NUM_EVT | Event pulses, one per event id |
| flt_match_i | input | NUM_CTR | Per-counter filter match from the external matcher |
| flt_val_o | output | 32*NUM_CTR | Filter value of each counter |
| flt_span_o | output | NUM_CTR | Filter span flag of each counter |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The bench sweeps all sixteen mask patterns through each set/clear pair. This exposes a decode that swaps the set and clear addresses, or that treats a written 0 as a clear: the read-back mask would diverge from the running OR/AND-NOT model.

Counting rounds drive computed event and filter patterns while changing the enable mask, the global enable and the selected ids, including ids past the event vector. A design that ignores any one gating term, or that wraps the id into range, ends a round with a wrong count.

A preload just below all ones checks that the wrap sets overflow and that the interrupt follows each of its three gates. A load under continuous events checks that the write wins over the same-cycle step; a design that let the step win would read one higher or lower.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;

  // Register byte offsets
  localparam logic [11:0] OFS_EVTYPE   = 12'h400;
  localparam logic [11:0] END_EVTYPE   = 12'h600;
  localparam logic [11:0] OFS_FILTER   = 12'hA00;
  localparam logic [11:0] END_FILTER   = 12'hC00;
  localparam logic [11:0] OFS_CEN_SET  = 12'hC00;
  localparam logic [11:0] OFS_CEN_CLR  = 12'hC20;
  localparam logic [11:0] OFS_IEN_SET  = 12'hC40;
  localparam logic [11:0] OFS_IEN_CLR  = 12'hC60;
  localparam logic [11:0] OFS_OVF_CLR  = 12'hC80;
  localparam logic [11:0] OFS_OVF_SET  = 12'hCC0;
  localparam logic [11:0] OFS_CFG      = 12'hE00;
  localparam logic [11:0] OFS_CTRL     = 12'hE04;
  localparam logic [11:0] OFS_EVMAP_LO = 12'hE20;
  localparam logic [11:0] OFS_EVMAP_HI = 12'hE28;
  localparam logic [11:0] OFS_IRQCTL   = 12'hE50;

  localparam int SPAN_BIT = 29;
  localparam int EID_W    = 16;
  localparam int FLT_W    = 32;

  // Decoded write strobes for the fixed control registers
  typedef struct packed {
    logic cen_set;
    logic cen_clr;
    logic ien_set;
    logic ien_clr;
    logic ovf_set;
    logic ovf_clr;
    logic ctrl;
    logic irqctl;
  } ctl_wr_t;

  // log2 of the counter stride in bytes
  function automatic int stride_shift(input int ctr_w);
    return (ctr_w > 32) ? 3 : 2;
  endfunction

  // Self-describing configuration word
  function automatic logic [63:0] cfg_word(input int n_ctr, input int ctr_w,
                                           input bit glob);
    logic [63:0] c;
    c        = '0;
    c[5:0]   = 6'(n_ctr - 1);
    c[13:8]  = 6'(ctr_w - 1);
    c[20]    = 1'b0;
    c[23]    = glob;
    return c;
  endfunction

  // Next value of a set/clear mask: software set, then clear, then hardware set
  function automatic logic [63:0] mask_next(input logic [63:0] cur,
                                            input logic [63:0] set_m,
                                            input logic [63:0] clr_m,
                                            input logic [63:0] hw_m);
    return ((cur | set_m) & ~clr_m) | hw_m;
  endfunction

endpackage

// File: rtl/perf_ctr_bitvec.sv
module perf_ctr_bitvec
  import perf_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [63:0] set_m, clr_m, hw_m, cur_m, nxt_m;

  always_comb begin
    set_m = '0;
    clr_m = '0;
    hw_m  = '0;
    cur_m = '0;
    if (set_we) set_m[W-1:0] = wmask;
    if (clr_we) clr_m[W-1:0] = wmask;
    hw_m[W-1:0]  = hw_set;
    cur_m[W-1:0] = q;
    nxt_m = mask_next(cur_m, set_m, clr_m, hw_m);
  end

  logic unused_upper;
  assign unused_upper = ^nxt_m[63:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt_m[W-1:0];
  end
endmodule

// File: rtl/perf_ctr_evsel.sv
module perf_ctr_evsel #(
  parameter int NUM_EVT = 8,
  parameter int ID_W    = 16
) (
  input  logic [ID_W-1:0]    evt_id,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit
);
  localparam int IX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic in_range;
  assign in_range = (evt_id < ID_W'(NUM_EVT));

  always_comb begin
    hit = 1'b0;
    if (in_range) hit = evt_i[evt_id[IX_W-1:0]];
  end
endmodule

// File: rtl/perf_ctr_slice.sv
module perf_ctr_slice #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         wrap
);
  // A step taken from all ones wraps; a same-cycle load cancels the step
  assign wrap = step & ~load & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= value + 1'b1;
  end
endmodule

// File: rtl/perf_ctr_group.sv
module perf_ctr_group
  import perf_ctr_pkg::*;
#(
  parameter int           NUM_CTR     = 4,
  parameter int           CTR_W       = 32,
  parameter int           NUM_EVT     = 8,
  parameter bit           GLOBAL_FLT  = 1'b0,
  parameter logic [127:0] EVT_SUPPORT = 128'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [11:0]              reg_addr,
  input  logic                     reg_wr,
  input  logic [63:0]              reg_wdata,
  input  logic                     reg_rd,
  output logic [63:0]              reg_rdata,
  input  logic [NUM_EVT-1:0]       evt_i,
  input  logic [NUM_CTR-1:0]       flt_match_i,
  output logic [NUM_CTR*FLT_W-1:0] flt_val_o,
  output logic [NUM_CTR-1:0]       flt_span_o,
  output logic                     irq_o
);
  localparam int          SSH        = stride_shift(CTR_W);
  localparam logic [11:0] ALIGN_MASK = 12'((1 << SSH) - 1);
  localparam logic [63:0] CFG_VALUE  = cfg_word(NUM_CTR, CTR_W, GLOBAL_FLT);

  // ---------------- address decode ----------------
  logic [11:0] ctr_slot, evt_slot, flt_slot;
  logic        ctr_hit, evt_hit, flt_hit;
  ctl_wr_t     cw;

  assign ctr_slot = reg_addr >> SSH;
  assign evt_slot = (reg_addr - OFS_EVTYPE) >> 2;
  assign flt_slot = (reg_addr - OFS_FILTER) >> 2;

  assign ctr_hit = (reg_addr < OFS_EVTYPE) && ((reg_addr & ALIGN_MASK) == 12'd0)
                   && (ctr_slot < 12'(NUM_CTR));
  assign evt_hit = (reg_addr >= OFS_EVTYPE) && (reg_addr < END_EVTYPE)
                   && (reg_addr[1:0] == 2'b00) && (evt_slot < 12'(NUM_CTR));
  assign flt_hit = (reg_addr >= OFS_FILTER) && (reg_addr < END_FILTER)
                   && (reg_addr[1:0] == 2'b00) && (flt_slot < 12'(NUM_CTR));

  always_comb begin
    cw         = '0;
    cw.cen_set = reg_wr && (reg_addr == OFS_CEN_SET);
    cw.cen_clr = reg_wr && (reg_addr == OFS_CEN_CLR);
    cw.ien_set = reg_wr && (reg_addr == OFS_IEN_SET);
    cw.ien_clr = reg_wr && (reg_addr == OFS_IEN_CLR);
    cw.ovf_set = reg_wr && (reg_addr == OFS_OVF_SET);
    cw.ovf_clr = reg_wr && (reg_addr == OFS_OVF_CLR);
    cw.ctrl    = reg_wr && (reg_addr == OFS_CTRL);
    cw.irqctl  = reg_wr && (reg_addr == OFS_IRQCTL);
  end

  // ---------------- global switches ----------------
  logic ctrl_en_q, irq_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      if (cw.ctrl)   ctrl_en_q <= reg_wdata[0];
      if (cw.irqctl) irq_en_q  <= reg_wdata[0];
    end
  end

  // ---------------- per-counter masks ----------------
  logic [NUM_CTR-1:0] cen_q, ien_q, ovf_q;
  logic [NUM_CTR-1:0] wrap_hit, load_hit, step_hit;
  logic [NUM_CTR-1:0] no_hw;
  logic               ovf_set_wr;

  assign no_hw      = '0;
  assign ovf_set_wr = cw.ovf_set;

  perf_ctr_bitvec #(.W(NUM_CTR)) u_cen (
    .clk(clk), .rst_n(rst_n), .set_we(cw.cen_set), .clr_we(cw.cen_clr),
    .wmask(reg_wdata[NUM_CTR-1:0]), .hw_set(no_hw), .q(cen_q));

  perf_ctr_bitvec #(.W(NUM_CTR)) u_ien (
    .clk(clk), .rst_n(rst_n), .set_we(cw.ien_set), .clr_we(cw.ien_clr),
    .wmask(reg_wdata[NUM_CTR-1:0]), .hw_set(no_hw), .q(ien_q));

  perf_ctr_bitvec #(.W(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n), .set_we(cw.ovf_set), .clr_we(cw.ovf_clr),
    .wmask(reg_wdata[NUM_CTR-1:0]), .hw_set(wrap_hit), .q(ovf_q));

  // ---------------- counters and selections ----------------
  logic [CTR_W-1:0]         cnt      [NUM_CTR];
  logic [EID_W-1:0]         evt_id_q [NUM_CTR];
  logic                     span_q   [NUM_CTR];
  logic [FLT_W-1:0]         flt_q    [NUM_CTR];
  logic [NUM_CTR-1:0]       sel_hit;
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [EID_W-1:0] id_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) id_r <= '0;
      else if (reg_wr && evt_hit && (evt_slot == 12'(i))) id_r <= reg_wdata[EID_W-1:0];
    end
    assign evt_id_q[i] = id_r;

    if (GLOBAL_FLT && (i > 0)) begin : g_shared
      // Only the first counter carries filter state in global mode
      assign span_q[i] = 1'b0;
      assign flt_q[i]  = '0;
    end else begin : g_own
      logic             span_r;
      logic [FLT_W-1:0] flt_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          span_r <= 1'b0;
          flt_r  <= '0;
        end else begin
          if (reg_wr && evt_hit && (evt_slot == 12'(i))) span_r <= reg_wdata[SPAN_BIT];
          if (reg_wr && flt_hit && (flt_slot == 12'(i))) flt_r  <= reg_wdata[FLT_W-1:0];
        end
      end
      assign span_q[i] = span_r;
      assign flt_q[i]  = flt_r;
    end

    if (GLOBAL_FLT) begin : g_bcast
      assign flt_val_o[i*FLT_W +: FLT_W] = flt_q[0];
      assign flt_span_o[i]               = span_q[0];
    end else begin : g_local
      assign flt_val_o[i*FLT_W +: FLT_W] = flt_q[i];
      assign flt_span_o[i]               = span_q[i];
    end

    perf_ctr_evsel #(.NUM_EVT(NUM_EVT), .ID_W(EID_W)) u_sel (
      .evt_id(id_r), .evt_i(evt_i), .hit(sel_hit[i]));

    assign load_hit[i] = reg_wr && ctr_hit && (ctr_slot == 12'(i));
    assign step_hit[i] = ctrl_en_q && cen_q[i] && flt_match_i[i] && sel_hit[i];

    perf_ctr_slice #(.W(CTR_W)) u_slice (
      .clk(clk), .rst_n(rst_n), .load(load_hit[i]),
      .load_val(reg_wdata[CTR_W-1:0]), .step(step_hit[i]),
      .value(cnt[i]), .wrap(wrap_hit[i]));

    assign cnt_flat[i*CTR_W +: CTR_W] = cnt[i];
  end

  // ---------------- interrupt ----------------
  assign irq_o = irq_en_q && |(ovf_q & ien_q);

  // ---------------- read path ----------------
  logic [63:0] rd_next;

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      OFS_CEN_SET, OFS_CEN_CLR: rd_next[NUM_CTR-1:0] = cen_q;
      OFS_IEN_SET, OFS_IEN_CLR: rd_next[NUM_CTR-1:0] = ien_q;
      OFS_OVF_SET, OFS_OVF_CLR: rd_next[NUM_CTR-1:0] = ovf_q;
      OFS_CFG:      rd_next    = CFG_VALUE;
      OFS_CTRL:     rd_next[0] = ctrl_en_q;
      OFS_EVMAP_LO: rd_next    = EVT_SUPPORT[63:0];
      OFS_EVMAP_HI: rd_next    = EVT_SUPPORT[127:64];
      OFS_IRQCTL:   rd_next[0] = irq_en_q;
      default:      ;
    endcase
    for (int i = 0; i < NUM_CTR; i++) begin
      if (ctr_hit && (ctr_slot == 12'(i))) rd_next[CTR_W-1:0] = cnt[i];
      if (evt_hit && (evt_slot == 12'(i))) begin
        rd_next[EID_W-1:0] = evt_id_q[i];
        rd_next[SPAN_BIT]  = span_q[i];
      end
      if (flt_hit && (flt_slot == 12'(i))) rd_next[FLT_W-1:0] = flt_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: rtl/perf_ctr_group_chk.sv
module perf_ctr_group_chk #(
  parameter int NUM_CTR = 4,
  parameter int CTR_W   = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq_o,
  input logic                     irq_en_q,
  input logic                     ctrl_en_q,
  input logic [NUM_CTR-1:0]       ovf_q,
  input logic [NUM_CTR-1:0]       ien_q,
  input logic [NUM_CTR-1:0]       wrap_hit,
  input logic [NUM_CTR-1:0]       load_hit,
  input logic                     ovf_set_wr,
  input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (ovf_q == '0 && cnt_flat == '0 && !irq_o));

  // R4
  no_count_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en_q && !(|load_hit)) |=> $stable(cnt_flat));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en_q && |(ovf_q & ien_q)));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    // R6
    wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_hit[i] |=> ovf_q[i]);

    // R3
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[i]) |-> $past(wrap_hit[i] || ovf_set_wr));
  end
endmodule

bind perf_ctr_group perf_ctr_group_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .irq_en_q(irq_en_q),
  .ctrl_en_q(ctrl_en_q), .ovf_q(ovf_q), .ien_q(ien_q), .wrap_hit(wrap_hit),
  .load_hit(load_hit), .ovf_set_wr(ovf_set_wr), .cnt_flat(cnt_flat));

// File: tb/perf_ctr_group_bench.sv
module perf_ctr_group_bench;
  localparam int NC = 4;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [63:0]   reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [63:0]   reg_rdata;
  logic [NE-1:0] evt_i = '0;
  logic [NC-1:0] flt_match_i = '0;
  logic [NC*32-1:0] flt_val_o;
  logic [NC-1:0] flt_span_o;
  logic          irq_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  perf_ctr_group u_perf_ctr_group (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_i(evt_i), .flt_match_i(flt_match_i), .flt_val_o(flt_val_o),
    .flt_span_o(flt_span_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  // Counting round with a software model of the gating
  task automatic run_round(input logic [3:0] en_mask, input logic [15:0] s0,
                           input logic [15:0] s1, input logic [15:0] s2,
                           input logic [15:0] s3, input bit gon,
                           input int cycles, input int seed);
    logic [31:0] exp_c [NC];
    logic [15:0] sel [NC];
    logic [63:0] d;
    logic [7:0]  ev;
    logic [3:0]  mt;
    sel[0] = s0; sel[1] = s1; sel[2] = s2; sel[3] = s3;
    wr(12'hE04, 64'd0);
    for (int i = 0; i < NC; i++) begin
      exp_c[i] = 32'(seed * 1000 + i * 77);
      wr(12'(i * 4), {32'd0, exp_c[i]});
      wr(12'(12'h400 + i * 4), {48'd0, sel[i]});
    end
    wr(12'hC20, 64'hF);
    wr(12'hC00, {60'd0, en_mask});
    wr(12'hE04, {63'd0, gon});
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      ev = 8'(c * 73 + seed * 29) ^ 8'(c >> 1);
      mt = 4'(c * 5 + seed) ^ 4'hA;
      evt_i = ev; flt_match_i = mt;
      for (int i = 0; i < NC; i++)
        if (gon && en_mask[i] && mt[i] && (sel[i] < 16'd8) && ev[sel[i][2:0]])
          exp_c[i] = exp_c[i] + 32'd1;
    end
    @(negedge clk);
    evt_i = '0; flt_match_i = '0;
    wr(12'hE04, 64'd0);
    for (int i = 0; i < NC; i++) begin
      rd(12'(i * 4), d);
      chk($sformatf("R4 round seed %0d counter %0d", seed, i), d, {32'd0, exp_c[i]});
    end
  endtask

  // Set/clear sweep over one mask pair
  task automatic sweep(input logic [11:0] sa, input logic [11:0] ca, input string nm);
    logic [3:0]  st;
    logic [63:0] d;
    st = '0;
    for (int m = 0; m < 16; m++) begin
      wr(sa, 64'(m));
      st = st | 4'(m);
      rd(sa, d);
      chk({"R3 set ", nm}, d, {60'd0, st});
      wr(ca, 64'(m ^ 5));
      st = st & ~4'(m ^ 5);
      rd(ca, d);
      chk({"R3 clr ", nm}, d, {60'd0, st});
    end
    wr(ca, 64'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", {63'd0, irq_o}, 64'd0);
    for (int i = 0; i < NC; i++) begin
      rd(12'(i * 4), d);
      chk("R1 counter zero", d, 64'd0);
    end
    rd(12'hC00, d); chk("R1 enable mask", d, 64'd0);
    rd(12'hC40, d); chk("R1 irq enable mask", d, 64'd0);
    rd(12'hC80, d); chk("R1 overflow mask", d, 64'd0);
    rd(12'hE04, d); chk("R1 global enable", d, 64'd0);
    rd(12'hE50, d); chk("R1 irq switch", d, 64'd0);

    // R2 configuration
    rd(12'hE00, d); chk("R2 config word", d, 64'h1F03);
    rd(12'hE20, d); chk("R2 event map low", d, 64'hFF);
    rd(12'hE28, d); chk("R2 event map high", d, 64'h0);

    // R3 set/clear pairs
    sweep(12'hC00, 12'hC20, "enable");
    sweep(12'hC40, 12'hC60, "irq enable");
    sweep(12'hCC0, 12'hC80, "overflow");

    // R8 event type and filter words
    for (int i = 0; i < NC; i++) begin
      wr(12'(12'h400 + i * 4), 64'(((i % 2) << 29) | (16'h10 + i)));
      wr(12'(12'hA00 + i * 4), 64'(32'h42 + i * 32'h100));
    end
    for (int i = 0; i < NC; i++) begin
      rd(12'(12'h400 + i * 4), d);
      chk("R8 event type readback", d, 64'(((i % 2) << 29) | (16'h10 + i)));
      rd(12'(12'hA00 + i * 4), d);
      chk("R8 filter readback", d, 64'(32'h42 + i * 32'h100));
      chk("R8 filter output", {32'd0, flt_val_o[i*32 +: 32]}, 64'(32'h42 + i * 32'h100));
      chk("R8 span output", {63'd0, flt_span_o[i]}, 64'(i % 2));
    end

    // R5 counter addressing and preload
    for (int i = 0; i < NC; i++) wr(12'(i * 4), 64'(32'hA5A50000 + i));
    for (int i = 0; i < NC; i++) begin
      rd(12'(i * 4), d);
      chk("R5 counter preload", d, 64'(32'hA5A50000 + i));
    end
    rd(12'h010, d); chk("R5 slot past last counter", d, 64'd0);

    // R4 counting under several gating patterns
    run_round(4'hF, 16'd0, 16'd3, 16'd5, 16'd7, 1'b1, 40, 1);
    run_round(4'h5, 16'd1, 16'd2, 16'd6, 16'd4, 1'b1, 50, 2);
    run_round(4'hF, 16'd2, 16'd6, 16'd9, 16'd200, 1'b1, 40, 3);
    run_round(4'hF, 16'd0, 16'd1, 16'd2, 16'd3, 1'b0, 30, 4);
    run_round(4'hA, 16'd4, 16'd4, 16'd4, 16'd4, 1'b1, 60, 5);

    // R6 wrap and R7 interrupt
    wr(12'hC20, 64'hF); wr(12'hC60, 64'hF); wr(12'hC80, 64'hF);
    wr(12'h408, 64'd1);
    wr(12'h008, 64'hFFFF_FFFE);
    wr(12'hC00, 64'h4);
    wr(12'hC40, 64'h4);
    wr(12'hE04, 64'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      evt_i = 8'h02; flt_match_i = 4'h4;
    end
    @(negedge clk);
    evt_i = '0; flt_match_i = '0;
    rd(12'h008, d); chk("R6 counter after wrap", d, 64'd1);
    rd(12'hC80, d); chk("R6 overflow bit set", d, 64'h4);
    chk("R7 irq low with switch off", {63'd0, irq_o}, 64'd0);
    wr(12'hE50, 64'd1);
    chk("R7 irq high", {63'd0, irq_o}, 64'd1);
    wr(12'hC60, 64'h4);
    chk("R7 irq low without enable", {63'd0, irq_o}, 64'd0);
    wr(12'hC40, 64'h4);
    chk("R7 irq back high", {63'd0, irq_o}, 64'd1);
    wr(12'hC80, 64'h4);
    chk("R7 irq low after clear", {63'd0, irq_o}, 64'd0);
    wr(12'hC40, 64'h1);
    wr(12'hCC0, 64'h1);
    chk("R7 irq from software set", {63'd0, irq_o}, 64'd1);
    wr(12'hC80, 64'hF);

    // R9 load wins over a same-cycle step
    wr(12'h400, 64'd1);
    wr(12'hC00, 64'h1);
    @(negedge clk);
    evt_i = 8'h02; flt_match_i = 4'h1;
    wr(12'h000, 64'h100);
    rd(12'h000, d); chk("R9 load then one step", d, 64'h101);
    rd(12'h000, d); chk("R9 counting resumes", d, 64'h103);
    @(negedge clk);
    evt_i = '0; flt_match_i = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule